// File: doc/BRIEF.md
# Shared Controller Port Auto-Select

This block decides which of two physical devices drives a single emulated controller port. One device is a quadrature mouse (two quadrature pairs and two buttons). The other is a digital joystick (four direction lines and one fire button). The block chooses the device from user activity alone. Touching the joystick in any way claims the port for the joystick. Only a mouse button press hands the port back to the mouse. Mouse movement never reclaims the port, because a mouse at rest can sit in any quadrature state and can jitter between neighbouring states.

All inputs pass through a two-flop synchroniser. A rising edge on a trigger line makes a one-cycle event, and the selection changes on events, not on levels. The port lines the emulated machine sees are registered outputs. The four shared direction pins carry either the joystick directions or the mouse quadrature. The button pins carry either the fire button or the two mouse buttons. The lines of the device that is not selected are masked. The logic is kept very small, with no counting filter.

Top module: `psw_autoswitch`

## Requirements
- R1: While `rst` is high at a clock edge, `sel_o` becomes 0 (mouse), and `port_dir_o` and `port_btn_o` become all zeros.
- R2: Every input line is synchronised by two flip-flops. A switch is triggered only by a low-to-high change of a trigger line. Holding a trigger line high causes no further switches, so a held fire button does not undo a later mouse-button switch.
- R3: A rising edge on any bit of `joy_dir_i` selects the joystick. `sel_o` changes on the third rising clock edge, counting the edge that first samples the new input as the first.
- R4: A rising edge on `joy_fire_i` selects the joystick, with the same latency as R3.
- R5: A rising edge on either bit of `mouse_btn_i` (bit 0 left, bit 1 right) selects the mouse, with the same latency as R3.
- R6: Activity on `mouse_quad_i` alone never changes `sel_o`.
- R7: If a joystick event and a mouse-button event reach the selector in the same cycle, the current selection is kept.
- R8: While the joystick is selected, `port_dir_o` equals the synchronised `joy_dir_i`, `port_btn_o[0]` equals the synchronised fire button, and `port_btn_o[1]` is 0. The mouse lines have no effect on the port.
- R9: While the mouse is selected, `port_dir_o` equals the synchronised `mouse_quad_i` and `port_btn_o` equals the synchronised `mouse_btn_i`. The joystick lines have no effect on the port.
- R10: `sel_o` is 1 for joystick and 0 for mouse. The port lines change on the same clock edge as `sel_o`, so the port never shows one device's data under the other device's select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| joy_dir_i | input | DIR_W (4) | Joystick direction lines, active high |
| joy_fire_i | input | 1 | Joystick fire button, active high |
| mouse_quad_i | input | DIR_W (4) | Mouse quadrature lines |
| mouse_btn_i | input | MBTN_W (2) | Mouse buttons, bit 0 left, bit 1 right, active high |
| sel_o | output | 1 | Current source: 1 joystick, 0 mouse |
| port_dir_o | output | DIR_W (4) | Shared direction / quadrature pins to the machine |
| port_btn_o | output | MBTN_W (2) | Shared button pins to the machine |

## Verification
An input change that the clock samples at edge k appears on the port at edge k+2. A switch it triggers shows on `sel_o` at that same edge k+2, because two synchroniser stages come first and then the select register and the port register load together. The bench's behavioural model keeps a short queue of sampled input snapshots and derives both results from the snapshot two edges old. It compares every output at every falling edge, so it never samples near the edge where outputs change. The directed checks after each stimulus wait four falling edges. That is more than the three edges needed, and the selection is held stable over the whole wait.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic {
    SRC_MOUSE = 1'b0,
    SRC_JOY   = 1'b1
  } src_t;
endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/psw_edge.sv
module psw_edge #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;

  // R2
  rise_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (rise & $past(rise)) == '0);
endmodule

// File: rtl/psw_arbiter.sv
module psw_arbiter
  import psw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic joy_hit,
  input  logic mouse_hit,
  output src_t sel_q,
  output src_t sel_d
);
  always_comb begin
    sel_d = sel_q;
    if (joy_hit && !mouse_hit)      sel_d = SRC_JOY;
    else if (mouse_hit && !joy_hit) sel_d = SRC_MOUSE;
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= SRC_MOUSE;
    else     sel_q <= sel_d;
  end

  // R7
  tie_keeps_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (joy_hit && mouse_hit) |=> $stable(sel_q));

  // R6
  joy_held_without_button_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SRC_JOY && !mouse_hit) |=> sel_q == SRC_JOY);
endmodule

// File: rtl/psw_mux.sv
module psw_mux
  import psw_pkg::*;
#(
  parameter int DIR_W  = 4,
  parameter int MBTN_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  src_t              sel_d,
  input  logic [DIR_W-1:0]  joy_dir,
  input  logic              joy_fire,
  input  logic [DIR_W-1:0]  quad,
  input  logic [MBTN_W-1:0] mbtn,
  output logic [DIR_W-1:0]  port_dir,
  output logic [MBTN_W-1:0] port_btn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      port_dir <= '0;
      port_btn <= '0;
    end else if (sel_d == SRC_JOY) begin
      port_dir <= joy_dir;
      port_btn <= MBTN_W'(joy_fire);
    end else begin
      port_dir <= quad;
      port_btn <= mbtn;
    end
  end

  // R8
  joy_masks_upper_btn_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_d == SRC_JOY) |=> port_btn[MBTN_W-1:1] == '0);
endmodule

// File: rtl/psw_autoswitch.sv
module psw_autoswitch
  import psw_pkg::*;
#(
  parameter int DIR_W       = 4,
  parameter int MBTN_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIR_W-1:0]  joy_dir_i,
  input  logic              joy_fire_i,
  input  logic [DIR_W-1:0]  mouse_quad_i,
  input  logic [MBTN_W-1:0] mouse_btn_i,
  output logic              sel_o,
  output logic [DIR_W-1:0]  port_dir_o,
  output logic [MBTN_W-1:0] port_btn_o
);
  localparam int JOY_W = DIR_W + 1;

  logic [JOY_W-1:0]  joy_s, joy_rise;
  logic [MBTN_W-1:0] mbtn_s, mbtn_rise;
  logic [DIR_W-1:0]  quad_s;
  src_t              sel_q, sel_d;
  logic              joy_hit, mouse_hit;

  psw_sync #(.W(JOY_W), .STAGES(SYNC_STAGES)) u_sync_joy (
    .clk(clk), .rst(rst), .d({joy_fire_i, joy_dir_i}), .q(joy_s));
  psw_sync #(.W(MBTN_W), .STAGES(SYNC_STAGES)) u_sync_btn (
    .clk(clk), .rst(rst), .d(mouse_btn_i), .q(mbtn_s));
  psw_sync #(.W(DIR_W), .STAGES(SYNC_STAGES)) u_sync_quad (
    .clk(clk), .rst(rst), .d(mouse_quad_i), .q(quad_s));

  psw_edge #(.W(JOY_W)) u_edge_joy (
    .clk(clk), .rst(rst), .lvl(joy_s), .rise(joy_rise));
  psw_edge #(.W(MBTN_W)) u_edge_btn (
    .clk(clk), .rst(rst), .lvl(mbtn_s), .rise(mbtn_rise));

  assign joy_hit   = |joy_rise;
  assign mouse_hit = |mbtn_rise;

  psw_arbiter u_arb (
    .clk(clk), .rst(rst), .joy_hit(joy_hit), .mouse_hit(mouse_hit),
    .sel_q(sel_q), .sel_d(sel_d));

  psw_mux #(.DIR_W(DIR_W), .MBTN_W(MBTN_W)) u_mux (
    .clk(clk), .rst(rst), .sel_d(sel_d),
    .joy_dir(joy_s[DIR_W-1:0]), .joy_fire(joy_s[DIR_W]),
    .quad(quad_s), .mbtn(mbtn_s),
    .port_dir(port_dir_o), .port_btn(port_btn_o));

  assign sel_o = (sel_q == SRC_JOY);

  // R6
  quad_never_reclaims_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_o && !mouse_hit) |=> sel_o);

  // R10
  joy_port_btn_follows_sel_chk: assert property (@(posedge clk) disable iff (rst)
    sel_o |-> port_btn_o[MBTN_W-1:1] == '0);
endmodule

// File: tb/psw_autoswitch_tb.sv
module psw_autoswitch_tb_top;
  localparam int DIR_W  = 4;
  localparam int MBTN_W = 2;
  localparam int VW     = 2*DIR_W + 1 + MBTN_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DIR_W-1:0]  joy_dir = '0;
  logic              joy_fire = 1'b0;
  logic [DIR_W-1:0]  quad = '0;
  logic [MBTN_W-1:0] mbtn = '0;
  logic              sel;
  logic [DIR_W-1:0]  pdir;
  logic [MBTN_W-1:0] pbtn;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    done     = 1'b0;

  always #10 clk = ~clk;

  psw_autoswitch #(.DIR_W(DIR_W), .MBTN_W(MBTN_W)) dut_i (
    .clk(clk), .rst(rst), .joy_dir_i(joy_dir), .joy_fire_i(joy_fire),
    .mouse_quad_i(quad), .mouse_btn_i(mbtn),
    .sel_o(sel), .port_dir_o(pdir), .port_btn_o(pbtn));

  // Reference model: snapshot layout {quad, mbtn, fire, dir}
  logic [VW-1:0]     hist[$];
  logic [VW-1:0]     cur, old, rs;
  logic              m_sel = 1'b0;
  logic [DIR_W-1:0]  m_dir = '0;
  logic [MBTN_W-1:0] m_btn = '0;
  logic              jt, mt;

  initial hist = '{'0, '0, '0, '0};

  always @(posedge clk) begin
    if (rst) begin
      hist = '{'0, '0, '0, '0};
      m_sel = 1'b0; m_dir = '0; m_btn = '0;
    end else begin
      hist.push_front({quad, mbtn, joy_fire, joy_dir});
      void'(hist.pop_back());
      cur = hist[2];
      old = hist[3];
      rs  = cur & ~old;
      jt  = |rs[DIR_W:0];
      mt  = |rs[DIR_W+MBTN_W:DIR_W+1];
      if (jt && !mt)      m_sel = 1'b1;
      else if (mt && !jt) m_sel = 1'b0;
      if (m_sel) begin
        m_dir = cur[DIR_W-1:0];
        m_btn = MBTN_W'(cur[DIR_W]);
      end else begin
        m_dir = cur[VW-1:DIR_W+MBTN_W+1];
        m_btn = cur[DIR_W+MBTN_W:DIR_W+1];
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (sel !== m_sel || pdir !== m_dir || pbtn !== m_btn) begin
        n_fail++;
        $display("FAIL %s model: sel=%0b dir=%h btn=%h expected sel=%0b dir=%h btn=%h",
                 cur_req, sel, pdir, pbtn, m_sel, m_dir, m_btn);
      end
    end
  end

  task automatic chk(input string req, input logic e_sel,
                     input logic [DIR_W-1:0] e_dir, input logic [MBTN_W-1:0] e_btn);
    n_checks++;
    if (sel !== e_sel || pdir !== e_dir || pbtn !== e_btn) begin
      n_fail++;
      $display("FAIL %s: sel=%0b dir=%h btn=%h expected sel=%0b dir=%h btn=%h",
               req, sel, pdir, pbtn, e_sel, e_dir, e_btn);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wt(3);
    // R1 reset state
    chk("R1", 1'b0, '0, '0);
    rst = 1'b0;
    wt(2);
    // R10 idle after reset: mouse selected
    chk("R10", 1'b0, '0, '0);

    // R9 mouse selected: quadrature and buttons pass
    cur_req = "R9";
    quad = 4'b0110; mbtn = 2'b00; joy_dir = 4'b0000; wt(4);
    chk("R9", 1'b0, 4'b0110, 2'b00);

    // R3 direction edge claims the port
    cur_req = "R3";
    joy_dir = 4'b0100; wt(4);
    chk("R3", 1'b1, 4'b0100, 2'b00);

    // R8 joystick selected: mouse lines masked
    cur_req = "R8";
    quad = 4'b1111; joy_fire = 1'b1; wt(4);
    chk("R8", 1'b1, 4'b0100, 2'b01);
    joy_fire = 1'b0; joy_dir = '0; wt(4);

    // R6 quadrature jitter alone never reclaims
    cur_req = "R6";
    for (int i = 0; i < 300; i++) begin
      quad = DIR_W'($urandom);
      @(negedge clk);
    end
    wt(4);
    chk("R6", 1'b1, 4'b0000, 2'b00);

    // R5 right button returns to mouse
    cur_req = "R5";
    quad = 4'b1001; mbtn = 2'b10; wt(4);
    chk("R5", 1'b0, 4'b1001, 2'b10);
    mbtn = 2'b00; wt(4);

    // R4 fire claims
    cur_req = "R4";
    joy_fire = 1'b1; wt(4);
    chk("R4", 1'b1, 4'b0000, 2'b01);

    // R2 held fire does not retrigger after left button
    cur_req = "R2";
    mbtn = 2'b01; wt(4);
    chk("R5", 1'b0, 4'b1001, 2'b01);
    wt(20);
    chk("R2", 1'b0, 4'b1001, 2'b01);
    joy_fire = 1'b0; mbtn = 2'b00; wt(4);

    // R7 tie while mouse selected
    cur_req = "R7";
    joy_dir = 4'b0001; mbtn = 2'b01; wt(4);
    chk("R7", 1'b0, 4'b1001, 2'b01);
    joy_dir = '0; mbtn = '0; wt(4);
    joy_dir = 4'b1000; wt(4);
    chk("R3", 1'b1, 4'b1000, 2'b00);
    joy_dir = '0; wt(4);
    // R7 tie while joystick selected
    joy_fire = 1'b1; mbtn = 2'b10; wt(4);
    chk("R7", 1'b1, 4'b0000, 2'b01);
    joy_fire = 1'b0; mbtn = '0; wt(4);

    // R10 mixed random traffic against the model
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      joy_dir  = (($urandom % 8) == 0) ? DIR_W'($urandom) : joy_dir;
      joy_fire = (($urandom % 10) == 0) ? ~joy_fire : joy_fire;
      mbtn     = (($urandom % 12) == 0) ? MBTN_W'($urandom) : mbtn;
      quad     = DIR_W'($urandom);
      @(negedge clk);
    end

    // R1 reset mid-run
    cur_req = "R1";
    rst = 1'b1; wt(2);
    chk("R1", 1'b0, '0, '0);
    rst = 1'b0; joy_dir = '0; joy_fire = 0; mbtn = '0; quad = '0; wt(6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule